// File: doc/BRIEF.md
# Internal Exception Flag Recorder

This block sits beside a processor core's control logic and records three internal error conditions: an opcode that the core does not recognise, an execution set whose instruction grouping breaks the packing rules, and an arithmetic overflow. Each condition arrives as a one-cycle pulse. The block latches it into a sticky status flag and captures the address of the offending execution set. It then raises one registered exception request toward the interrupt controller, tagged with a one-hot cause.

The exceptions are imprecise. The request appears a cycle after detection, and instruction flow goes on until the controller acknowledges the request. Software reads the flags and clears them with write-one-to-clear strobes. While a flag is still set, further events of that type are dropped. Overflow is recorded only while the overflow-enable mode bit is 1. When several events arrive in the same cycle, a fixed priority picks the one that is reported.

Top module: `excp_flag_recorder`

## Requirements
- R1: Reset (rst_n low) clears flag_status, exc_addr, exc_req and exc_cause to zero.
- R2: An accepted event sets its flag_status bit on the next clock edge: bit 0 for illegal opcode, bit 1 for illegal grouping, bit 2 for overflow.
- R3: A flag_status bit stays set until a cycle in which its flag_clr bit is 1. A flag_clr bit aimed at a bit that is already clear has no effect.
- R4: An event whose flag is set, with no clear of that flag in the same cycle, is ignored: no request, no cause change, no address change.
- R5: A clear and a new event of the same type in the same cycle leave the flag set, and the event is accepted as a new exception.
- R6: An overflow event is accepted only when ovf_enable is 1. Otherwise it changes no flag, request or address.
- R7: Among events accepted in the same cycle, illegal opcode wins over illegal grouping, and illegal grouping wins over overflow. exc_cause is one-hot with the same bit positions as flag_status.
- R8: Accepted events that lose arbitration still set their own flags, but they do not change exc_addr or exc_cause.
- R9: The winning event's exec_addr is written to exc_addr on the next edge and overwrites any earlier value.
- R10: exc_req and exc_cause hold until exc_ack is 1. After an ack with no new winner, both read zero on the next edge. An ack in the same cycle as a new winner leaves exc_req at 1 with the new cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_illegal_op | input | 1 | Pulse: unrecognised opcode detected |
| ev_bad_group | input | 1 | Pulse: illegal execution-set grouping detected |
| ev_overflow | input | 1 | Pulse: arithmetic overflow detected |
| ovf_enable | input | 1 | Mode bit allowing overflow to be recorded |
| exec_addr | input | ADDR_W | Address of the execution set in flight |
| flag_clr | input | 3 | Write-one-to-clear strobes for the flags |
| exc_ack | input | 1 | Controller acknowledge of the request |
| flag_status | output | 3 | Sticky flags: bit0 opcode, bit1 grouping, bit2 overflow |
| exc_addr | output | ADDR_W | Captured execution-set address |
| exc_req | output | 1 | Registered exception request |
| exc_cause | output | 3 | One-hot cause of the pending request |

## Verification
The bench targets a clear and a same-type event in the same cycle. A design that lets the clear win would drop the flag and miss the exception. It fires all three events together and then two at a time. A design with the wrong priority, or one that lets losers overwrite the address, reports the wrong cause or address. It also repeats events while their flags are set and sends overflow with the enable low. A leaky design raises a request or moves the captured address. Acks that arrive together with a new winner check that a fresh exception is not lost.

// File: rtl/excp_rec_pkg.sv
package excp_rec_pkg;

    localparam int unsigned NTYPES  = 3;
    localparam int unsigned IDX_OP  = 0;
    localparam int unsigned IDX_GRP = 1;
    localparam int unsigned IDX_OVF = 2;

    typedef logic [NTYPES-1:0] type_vec_t;

endpackage

// File: rtl/excp_event_gate.sv
module excp_event_gate
    import excp_rec_pkg::*;
#(
    parameter int unsigned N       = NTYPES,
    parameter int unsigned OVF_POS = IDX_OVF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] flags_q,
    input  logic [N-1:0] clr,
    input  logic         ovf_en,
    output logic [N-1:0] accepted
);

    for (genvar i = 0; i < N; i++) begin : g_gate
        logic mode_ok;
        if (i == OVF_POS) begin : g_mode
            assign mode_ok = ovf_en;
        end else begin : g_free
            assign mode_ok = 1'b1;
        end
        // gate is open when the flag is clear or is being cleared this cycle (R5)
        assign accepted[i] = ev[i] & mode_ok & (~flags_q[i] | clr[i]);

        p_no_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !ev[i] |-> !accepted[i]);
    end

endmodule

// File: rtl/excp_prio_pick.sv
module excp_prio_pick #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cand,
    output logic [N-1:0] winner,
    output logic         any
);

    always_comb begin
        winner = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                winner = '0;
                winner[i] = 1'b1;
            end
        end
    end

    assign any = |cand;

    p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(winner) && ((winner & ~cand) == '0));
    p_lowest_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cand[0] |-> winner[0]);
    p_any_r7: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> ($countones(winner) == 1));

endmodule

// File: rtl/excp_flag_bank.sv
module excp_flag_bank #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] accepted,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags_q
);

    logic [N-1:0] flags_d;

    always_comb begin
        flags_d = (flags_q & ~clr) | accepted;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
            accepted[i] |=> flags_q[i]);
        p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
            flags_q[i] && !clr[i] |=> flags_q[i]);
        p_stay_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !flags_q[i] && !accepted[i] |=> !flags_q[i]);
    end

endmodule

// File: rtl/excp_req_tracker.sv
module excp_req_tracker #(
    parameter int unsigned N      = 3,
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      winner,
    input  logic              any,
    input  logic [ADDR_W-1:0] exec_addr,
    input  logic              ack,
    output logic              req_q,
    output logic [N-1:0]      cause_q,
    output logic [ADDR_W-1:0] addr_q
);

    typedef struct packed {
        logic              req;
        logic [N-1:0]      cause;
        logic [ADDR_W-1:0] addr;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (any) begin
            st_d.req   = 1'b1;
            st_d.cause = winner;
            st_d.addr  = exec_addr;
        end else if (ack) begin
            st_d.req   = 1'b0;
            st_d.cause = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_q   = st_q.req;
    assign cause_q = st_q.cause;
    assign addr_q  = st_q.addr;

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_q && !ack |=> req_q);
    p_ack_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack && !any |=> !req_q && (cause_q == '0));
    p_cause_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_q == (cause_q != '0));
    p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        any |=> (addr_q == $past(exec_addr)));

endmodule

// File: rtl/excp_flag_recorder.sv
module excp_flag_recorder
    import excp_rec_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_illegal_op,
    input  logic              ev_bad_group,
    input  logic              ev_overflow,
    input  logic              ovf_enable,
    input  logic [ADDR_W-1:0] exec_addr,
    input  logic [2:0]        flag_clr,
    input  logic              exc_ack,
    output logic [2:0]        flag_status,
    output logic [ADDR_W-1:0] exc_addr,
    output logic              exc_req,
    output logic [2:0]        exc_cause
);

    type_vec_t ev_vec, accepted, winner, flags_q;
    logic      any_win;

    always_comb begin
        ev_vec          = '0;
        ev_vec[IDX_OP]  = ev_illegal_op;
        ev_vec[IDX_GRP] = ev_bad_group;
        ev_vec[IDX_OVF] = ev_overflow;
    end

    excp_event_gate #(.N(NTYPES), .OVF_POS(IDX_OVF)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev_vec),
        .flags_q  (flags_q),
        .clr      (flag_clr),
        .ovf_en   (ovf_enable),
        .accepted (accepted)
    );

    excp_prio_pick #(.N(NTYPES)) u_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .cand   (accepted),
        .winner (winner),
        .any    (any_win)
    );

    excp_flag_bank #(.N(NTYPES)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .accepted (accepted),
        .clr      (flag_clr),
        .flags_q  (flags_q)
    );

    excp_req_tracker #(.N(NTYPES), .ADDR_W(ADDR_W)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .winner    (winner),
        .any       (any_win),
        .exec_addr (exec_addr),
        .ack       (exc_ack),
        .req_q     (exc_req),
        .cause_q   (exc_cause),
        .addr_q    (exc_addr)
    );

    assign flag_status = flags_q;

    // all flags set and none cleared: every event is blocked
    p_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (&flag_status) && (flag_clr == '0) |=> $stable(exc_addr));
    p_ovf_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_enable && !flag_status[IDX_OVF] |=> !flag_status[IDX_OVF]);
    p_cause_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(exc_cause));
    p_loser_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_illegal_op && (!flag_status[IDX_OP] || flag_clr[IDX_OP]) && ev_overflow
        |=> !exc_cause[IDX_OVF]);

endmodule

// File: tb/excp_flag_recorder_tb.sv
module excp_flag_recorder_tb;

    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ev_op = 1'b0, ev_grp = 1'b0, ev_ovf = 1'b0;
    logic              ovf_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [2:0]        clr = '0;
    logic              ack = 1'b0;
    logic [2:0]        status;
    logic [ADDR_W-1:0] caddr;
    logic              req;
    logic [2:0]        cause;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    excp_flag_recorder #(.ADDR_W(ADDR_W)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev_illegal_op (ev_op),
        .ev_bad_group  (ev_grp),
        .ev_overflow   (ev_ovf),
        .ovf_enable    (ovf_en),
        .exec_addr     (addr),
        .flag_clr      (clr),
        .exc_ack       (ack),
        .flag_status   (status),
        .exc_addr      (caddr),
        .exc_req       (req),
        .exc_cause     (cause)
    );

    typedef struct packed {
        logic [2:0]  ev;      // {ovf, grp, op}
        logic        en;
        logic [2:0]  clr;
        logic        ack;
        logic [15:0] addr;
        logic [2:0]  e_st;
        logic        e_req;
        logic [2:0]  e_cause;
        logic [15:0] e_addr;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 15;
    localparam logic [50:0] VEC [NV] = '{
        {3'b001,1'b0,3'b000,1'b0,16'h0100, 3'b001,1'b1,3'b001,16'h0100,4'd2},  // R2 R9 opcode accepted
        {3'b001,1'b0,3'b000,1'b0,16'h0104, 3'b001,1'b1,3'b001,16'h0100,4'd4},  // R4 repeat blocked
        {3'b000,1'b0,3'b000,1'b1,16'h0000, 3'b001,1'b0,3'b000,16'h0100,4'd10}, // R10 ack drops req
        {3'b100,1'b0,3'b000,1'b0,16'h0108, 3'b001,1'b0,3'b000,16'h0100,4'd6},  // R6 overflow disabled
        {3'b100,1'b1,3'b000,1'b0,16'h010C, 3'b101,1'b1,3'b100,16'h010C,4'd6},  // R6 overflow enabled
        {3'b000,1'b0,3'b001,1'b0,16'h0000, 3'b100,1'b1,3'b100,16'h010C,4'd3},  // R3 clear opcode flag
        {3'b011,1'b0,3'b000,1'b0,16'h0110, 3'b111,1'b1,3'b001,16'h0110,4'd7},  // R7 R8 op beats grp
        {3'b010,1'b0,3'b010,1'b1,16'h0114, 3'b111,1'b1,3'b010,16'h0114,4'd5},  // R5 R10 clear+event, ack+winner
        {3'b000,1'b0,3'b000,1'b1,16'h0000, 3'b111,1'b0,3'b000,16'h0114,4'd10}, // R10 ack
        {3'b000,1'b0,3'b111,1'b0,16'h0000, 3'b000,1'b0,3'b000,16'h0114,4'd3},  // R3 clear all
        {3'b111,1'b1,3'b000,1'b0,16'h0118, 3'b111,1'b1,3'b001,16'h0118,4'd7},  // R7 R8 all three
        {3'b110,1'b1,3'b000,1'b1,16'h011C, 3'b111,1'b0,3'b000,16'h0118,4'd4},  // R4 blocked, ack drops
        {3'b110,1'b1,3'b011,1'b0,16'h0120, 3'b110,1'b1,3'b010,16'h0120,4'd5},  // R5 grp reopens, ovf blocked
        {3'b000,1'b0,3'b100,1'b0,16'h0000, 3'b010,1'b1,3'b010,16'h0120,4'd3},  // R3 clear overflow
        {3'b100,1'b0,3'b001,1'b0,16'h0124, 3'b010,1'b1,3'b010,16'h0120,4'd3}   // R3 R6 clear of clear bit
    };

    task automatic check(input string tag, input string what,
                         input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        check("R1", "status", {29'd0, status}, 0);
        check("R1", "req", {31'd0, req}, 0);
        check("R1", "cause", {29'd0, cause}, 0);
        check("R1", "addr", caddr, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            vec_t v;
            string t;
            v = vec_t'(VEC[k]);
            t = $sformatf("R%0d vec%0d", v.tag, k);
            @(negedge clk);
            {ev_ovf, ev_grp, ev_op} = v.ev;
            ovf_en = v.en;
            clr    = v.clr;
            ack    = v.ack;
            addr   = {16'd0, v.addr};
            @(posedge clk);
            #2;
            check(t, "status", {29'd0, status}, {29'd0, v.e_st});
            check(t, "req", {31'd0, req}, {31'd0, v.e_req});
            check(t, "cause", {29'd0, cause}, {29'd0, v.e_cause});
            check(t, "addr", caddr, {16'd0, v.e_addr});
        end

        // R10: request holds across idle cycles without ack
        @(negedge clk);
        {ev_ovf, ev_grp, ev_op} = 3'b000;
        clr = '0;
        ack = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check("R10", "req held", {31'd0, req}, 1);
        check("R10", "cause held", {29'd0, cause}, 3'b010);

        // R1: reset in mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        check("R1", "status mid", {29'd0, status}, 0);
        check("R1", "req mid", {31'd0, req}, 0);
        check("R1", "addr mid", caddr, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: full-width address capture
        @(negedge clk);
        ev_grp = 1'b1;
        addr   = 32'hDEAD_BEE0;
        @(posedge clk);
        #2;
        check("R9", "wide addr", caddr, 32'hDEAD_BEE0);
        check("R7", "grp cause", {29'd0, cause}, 3'b010);
        @(negedge clk);
        ev_grp = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule